// File: doc/BRIEF.md
# Remote Terminal Transmit Data Loader

This block runs the subsystem half of a transmit message in a serial-bus remote terminal. When the protocol front end hands over a validated command word, the loader first wipes the 32-word message buffer by writing zeros to every location. It skips that wipe when the command is the wrap-around transmit. For a transmit command it then drives an active-low command strobe for 8.5 µs, on the 1 µs grid of the bit clock, and shows the command word on a parallel bus for the whole strobe.

When the strobe releases, the loader stops if the terminal is busy. Otherwise it takes a burst of words from the subsystem, one for each subsystem strobe, and writes them into consecutive buffer locations. The transmit serializer later reads them from there. Strobes that come faster than once per microsecond are ignored. A pause longer than 16 µs ends the burst with an error pulse. A completion pulse marks the point where the expected number of words has been written. That number is one less when the checksum word is to be generated downstream.

Top module: `rt_tx_loader`

## Requirements
- R1: After reset, `cmd_strb_n` is 1, `cmd_bus` is 0, and `buf_we`, `load_done` and `load_err` are 0.
- R2: A command (pulse on `cmd_valid`) that is not wrap-around transmit produces 32 zero writes to buffer addresses 0 to 31, in consecutive cycles.
- R3: A wrap-around transmit command produces no clearing write. Wrap-around transmit means bit 10 = 1 (transmit) and bits 9:5 = `WRAP_SA` (default 30).
- R4: A transmit command drives `cmd_strb_n` low for 8.5 µs (425 clock cycles by default). The strobe starts on a 1 µs boundary, and `cmd_bus` equals the command word while it is low and 0 otherwise. A receive command (bit 10 = 0) gives no strobe.
- R5: If `busy` is 1 when the strobe ends, no data word is written and neither `load_done` nor `load_err` pulses.
- R6: After the strobe ends, each accepted `ss_strb` writes `ss_data` to the next buffer address, starting at 0. The write appears one cycle after the strobe, and no write happens while the strobe is low.
- R7: The word count is in bits 4:0, where 0 means 32. `load_done` pulses once, together with the write that makes the written count equal the target.
- R8: With `chk_en` = 1 at command time, the target is the word count minus one. A count of 1 then completes as the strobe ends. Strobes after completion write nothing.
- R9: An `ss_strb` arriving less than 1 µs (50 cycles) after the previous accepted one is ignored. One arriving exactly 1 µs after it is accepted.
- R10: A gap of exactly 16 µs (800 cycles) between words is accepted. A longer gap, counted from the strobe's end or from the last accepted word, pulses `load_err` and ends the burst.
- R11: A new `cmd_valid` at any point abandons the sequence in progress and starts the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 cycles per µs by default) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: validated command word present |
| cmd_word | input | 16 | Command word: bit 10 transmit, bits 9:5 subaddress, bits 4:0 word count |
| chk_en | input | 1 | Checksum generated downstream; the load target is reduced by one |
| busy | input | 1 | Busy bit of the status response |
| ss_strb | input | 1 | Subsystem word strobe, one cycle |
| ss_data | input | 16 | Subsystem data word |
| cmd_strb_n | output | 1 | Active-low command strobe |
| cmd_bus | output | 16 | Command word during the strobe, otherwise 0 |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 5 | Buffer write address |
| buf_wdata | output | 16 | Buffer write data |
| load_done | output | 1 | Pulse: load target reached |
| load_err | output | 1 | Pulse: word gap too long, burst abandoned |

## Verification
Bursts are driven with normal spacing, with a spacing of exactly 1 µs, and with a strobe at 49 cycles. Together these separate accepted words from ignored ones at the lower rate limit. A gap of exactly 800 cycles followed by silence separates the upper limit from the timeout. Transmit, receive and wrap-around commands are compared by their clearing writes and by whether a strobe appears. The busy, checksum-enabled and single-word-with-checksum runs show whether a burst is skipped, shortened or completed with no words at all. A command issued in the middle of a burst shows that the abandoned load neither completes nor times out.

// File: rtl/rt_txl_pkg.sv
package rt_txl_pkg;

    localparam int WORD_W    = 16;
    localparam int BUF_WORDS = 32;
    localparam int ADDR_W    = $clog2(BUF_WORDS);
    localparam int CNT_W     = ADDR_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ALIGN,
        ST_STROBE,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] raw;
        logic              xmit;
        logic [4:0]        subaddr;
        logic [4:0]        wcount;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.raw     = w;
        c.xmit    = w[10];
        c.subaddr = w[9:5];
        c.wcount  = w[4:0];
        return c;
    endfunction

    function automatic logic keeps_buffer(input cmd_t c, input logic [4:0] wrap_sa);
        return c.xmit && (c.subaddr == wrap_sa);
    endfunction

    function automatic logic [CNT_W-1:0] words_due(input cmd_t c, input logic chk);
        logic [CNT_W-1:0] n;
        n = (c.wcount == 5'd0) ? CNT_W'(BUF_WORDS) : CNT_W'(c.wcount);
        return chk ? n - CNT_W'(1) : n;
    endfunction

endpackage

// File: rtl/rt_txl_tick.sv
module rt_txl_tick #(
    parameter int CYC_PER_US = 50
) (
    input  logic clk,
    input  logic rst,
    output logic us_tick,
    output logic half_tick
);
    localparam int CW = (CYC_PER_US > 2) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);
    localparam logic [CW-1:0] MID  = CW'(CYC_PER_US / 2 - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
    end

    assign us_tick   = (cnt_q == LAST);
    assign half_tick = us_tick || (cnt_q == MID);

    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST) else $error("tick counter out of range"); // R4

endmodule

// File: rtl/rt_txl_rate.sv
module rt_txl_rate #(
    parameter int CYC_PER_US = 50,
    parameter int MIN_GAP_US = 1,
    parameter int MAX_GAP_US = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic first,
    input  logic ss_strb,
    output logic accept,
    output logic timeout
);
    localparam int TOUT = MAX_GAP_US * CYC_PER_US;
    localparam int MINC = MIN_GAP_US * CYC_PER_US;
    localparam int GW   = $clog2(TOUT + 1);
    localparam logic [GW-1:0] TOUT_W = GW'(TOUT);
    localparam logic [GW-1:0] MINC_W = GW'(MINC);

    // Cycles since the burst opened or the last accepted word; saturates.
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || !active || accept) gap_q <= GW'(1);
        else if (gap_q != TOUT_W)     gap_q <= gap_q + GW'(1);
    end

    assign accept  = active && ss_strb && (first || gap_q >= MINC_W);
    assign timeout = active && !ss_strb && (gap_q == TOUT_W);

    AST_NO_ACCEPT_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !accept) else $error("word accepted after timeout"); // R10

endmodule

// File: rtl/rt_txl_seq.sv
module rt_txl_seq
    import rt_txl_pkg::*;
#(
    parameter int          STRB_HALF_US = 17,
    parameter logic [4:0]  WRAP_SA      = 5'd30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              chk_en,
    input  logic              busy,
    input  logic [WORD_W-1:0] ss_data,
    input  logic              us_tick,
    input  logic              half_tick,
    input  logic              accept,
    input  logic              timeout,
    output logic              load_active,
    output logic              load_first,
    output logic              cmd_strb_n,
    output logic [WORD_W-1:0] cmd_bus,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [WORD_W-1:0] buf_wdata,
    output logic              load_done,
    output logic              load_err
);
    localparam int HW = $clog2(STRB_HALF_US + 1);
    localparam logic [HW-1:0]    HALF_LAST = HW'(STRB_HALF_US - 1);
    localparam logic [CNT_W-1:0] CLR_LAST  = CNT_W'(BUF_WORDS - 1);

    seq_state_e        state_q;
    cmd_t              cmd_q;
    cmd_t              cmd_in;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  tgt_q;
    logic [HW-1:0]     half_q;
    logic              strb_n_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              done_q;
    logic              err_q;

    assign cmd_in = decode_cmd(cmd_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cmd_q    <= '0;
            cnt_q    <= '0;
            tgt_q    <= '0;
            half_q   <= '0;
            strb_n_q <= 1'b1;
            we_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            we_q   <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (cmd_valid) begin
                cmd_q    <= cmd_in;
                tgt_q    <= words_due(cmd_in, chk_en);
                cnt_q    <= '0;
                strb_n_q <= 1'b1;
                if (keeps_buffer(cmd_in, WRAP_SA)) state_q <= ST_ALIGN;
                else                               state_q <= ST_CLEAR;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_CLEAR: begin
                        we_q    <= 1'b1;
                        addr_q  <= cnt_q[ADDR_W-1:0];
                        wdata_q <= '0;
                        if (cnt_q == CLR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= cmd_q.xmit ? ST_ALIGN : ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                    end
                    ST_ALIGN: begin
                        if (us_tick) begin
                            strb_n_q <= 1'b0;
                            half_q   <= '0;
                            state_q  <= ST_STROBE;
                        end
                    end
                    ST_STROBE: begin
                        if (half_tick) begin
                            if (half_q == HALF_LAST) begin
                                strb_n_q <= 1'b1;
                                cnt_q    <= '0;
                                if (busy) begin
                                    state_q <= ST_IDLE;
                                end else if (tgt_q == '0) begin
                                    done_q  <= 1'b1;
                                    state_q <= ST_IDLE;
                                end else begin
                                    state_q <= ST_LOAD;
                                end
                            end else begin
                                half_q <= half_q + HW'(1);
                            end
                        end
                    end
                    ST_LOAD: begin
                        if (timeout) begin
                            err_q   <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (accept) begin
                            we_q    <= 1'b1;
                            addr_q  <= cnt_q[ADDR_W-1:0];
                            wdata_q <= ss_data;
                            cnt_q   <= cnt_q + CNT_W'(1);
                            if (cnt_q + CNT_W'(1) == tgt_q) begin
                                done_q  <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign load_active = (state_q == ST_LOAD);
    assign load_first  = (cnt_q == '0);
    assign cmd_strb_n  = strb_n_q;
    assign cmd_bus     = strb_n_q ? '0 : cmd_q.raw;
    assign buf_we      = we_q;
    assign buf_addr    = addr_q;
    assign buf_wdata   = wdata_q;
    assign load_done   = done_q;
    assign load_err    = err_q;

    AST_STRB_ON_US_GRID: assert property (@(posedge clk) disable iff (rst)
        $fell(strb_n_q) |-> $past(us_tick)) else $error("strobe off grid"); // R4

    AST_NO_WRITE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        !strb_n_q |-> !we_q) else $error("write during strobe"); // R6

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q)) else $error("done and error together"); // R10

    AST_DONE_STRB_HIGH: assert property (@(posedge clk) disable iff (rst)
        done_q |-> strb_n_q) else $error("done while strobe low"); // R7

endmodule

// File: rtl/rt_tx_loader.sv
module rt_tx_loader
    import rt_txl_pkg::*;
#(
    parameter int          CYC_PER_US   = 50,
    parameter int          STRB_HALF_US = 17,
    parameter int          MIN_GAP_US   = 1,
    parameter int          MAX_GAP_US   = 16,
    parameter logic [4:0]  WRAP_SA      = 5'd30
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        chk_en,
    input  logic        busy,
    input  logic        ss_strb,
    input  logic [15:0] ss_data,
    output logic        cmd_strb_n,
    output logic [15:0] cmd_bus,
    output logic        buf_we,
    output logic [4:0]  buf_addr,
    output logic [15:0] buf_wdata,
    output logic        load_done,
    output logic        load_err
);
    logic us_tick;
    logic half_tick;
    logic accept;
    logic timeout;
    logic load_active;
    logic load_first;

    rt_txl_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .us_tick   (us_tick),
        .half_tick (half_tick)
    );

    rt_txl_rate #(
        .CYC_PER_US (CYC_PER_US),
        .MIN_GAP_US (MIN_GAP_US),
        .MAX_GAP_US (MAX_GAP_US)
    ) u_rate (
        .clk     (clk),
        .rst     (rst),
        .active  (load_active),
        .first   (load_first),
        .ss_strb (ss_strb),
        .accept  (accept),
        .timeout (timeout)
    );

    rt_txl_seq #(
        .STRB_HALF_US (STRB_HALF_US),
        .WRAP_SA      (WRAP_SA)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_word    (cmd_word),
        .chk_en      (chk_en),
        .busy        (busy),
        .ss_data     (ss_data),
        .us_tick     (us_tick),
        .half_tick   (half_tick),
        .accept      (accept),
        .timeout     (timeout),
        .load_active (load_active),
        .load_first  (load_first),
        .cmd_strb_n  (cmd_strb_n),
        .cmd_bus     (cmd_bus),
        .buf_we      (buf_we),
        .buf_addr    (buf_addr),
        .buf_wdata   (buf_wdata),
        .load_done   (load_done),
        .load_err    (load_err)
    );

endmodule

// File: tb/test_rt_tx_loader.sv
module test_rt_tx_loader;

    localparam int STRB_CYC = 425;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        chk_en = 1'b0;
    logic        busy = 1'b0;
    logic        ss_strb = 1'b0;
    logic [15:0] ss_data = '0;
    logic        cmd_strb_n;
    logic [15:0] cmd_bus;
    logic        buf_we;
    logic [4:0]  buf_addr;
    logic [15:0] buf_wdata;
    logic        load_done;
    logic        load_err;

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    bit finished = 0;

    logic [20:0] exp_q[$];
    string       exp_tag[$];

    always #10 clk = ~clk;

    rt_tx_loader i_rt_tx_loader (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .chk_en(chk_en), .busy(busy), .ss_strb(ss_strb), .ss_data(ss_data),
        .cmd_strb_n(cmd_strb_n), .cmd_bus(cmd_bus), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .load_done(load_done),
        .load_err(load_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every buffer write must match the next expected item.
    always @(negedge clk) begin
        if (!rst) begin
            if (buf_we) begin
                wr_cnt++;
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R6 unexpected write: actual addr %0d data %0h expected none",
                             buf_addr, buf_wdata);
                end else begin
                    logic [20:0] item;
                    string tag;
                    item = exp_q.pop_front();
                    tag  = exp_tag.pop_front();
                    if ({buf_addr, buf_wdata} != item) begin
                        fails++;
                        $display("FAIL %s write: actual addr %0d data %0h expected addr %0d data %0h",
                                 tag, buf_addr, buf_wdata, item[20:16], item[15:0]);
                    end
                end
            end
            if (load_done) done_cnt++;
            if (load_err)  err_cnt++;
        end
    end

    function automatic logic [15:0] mk(input bit tx, input int sa, input int wc);
        return {5'd7, tx, 5'(sa), 5'(wc)};
    endfunction

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [15:0] w, input logic chk, input bit clears);
        if (clears) begin
            for (int i = 0; i < 32; i++) begin
                exp_q.push_back({5'(i), 16'h0000});
                exp_tag.push_back("R2");
            end
        end
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        chk_en    = chk;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] d, input bit acc, input int addr, input string tag);
        if (acc) begin
            exp_q.push_back({5'(addr), d});
            exp_tag.push_back(tag);
        end
        ss_strb = 1'b1;
        ss_data = d;
        @(negedge clk);
        ss_strb = 1'b0;
    endtask

    task automatic wait_strobe(input logic [15:0] w);
        int lim;
        int width;
        bit bus_ok;
        lim = 0;
        while (cmd_strb_n && lim < 300) begin
            @(negedge clk);
            lim++;
        end
        chk(!cmd_strb_n, "R4", "strobe seen", int'(cmd_strb_n), 0);
        width = 0;
        bus_ok = 1;
        while (!cmd_strb_n && width < 1000) begin
            if (cmd_bus != w) bus_ok = 0;
            width++;
            @(negedge clk);
        end
        chk(width == STRB_CYC, "R4", "strobe width", width, STRB_CYC);
        chk(bus_ok, "R4", "command on bus during strobe", int'(bus_ok), 1);
        chk(cmd_bus == 16'h0, "R4", "bus idle after strobe", int'(cmd_bus), 0);
    endtask

    initial begin
        int d0;
        int e0;
        int w0;
        bit low_seen;

        gap(3);
        chk(cmd_strb_n == 1'b1 && cmd_bus == 0, "R1", "strobe/bus in reset", int'(cmd_bus), 0);
        chk(!buf_we && !load_done && !load_err, "R1", "flags in reset",
            int'({buf_we, load_done, load_err}), 0);
        @(negedge clk);
        rst = 1'b0;
        gap(2);
        chk(cmd_strb_n == 1'b1 && !buf_we, "R1", "idle after reset", int'(buf_we), 0);

        // T1: transmit, 4 words, no checksum
        d0 = done_cnt;
        send_cmd(mk(1, 3, 4), 1'b0, 1);
        wait_strobe(mk(1, 3, 4));
        gap(5);
        for (int i = 0; i < 4; i++) begin
            pulse(16'hA100 + 16'(i), 1, i, "R6");
            if (i == 2) begin
                gap(5);
                chk(done_cnt == d0, "R7", "no done before last word", done_cnt - d0, 0);
                gap(94);
            end else gap(99);
        end
        chk(done_cnt == d0 + 1, "R7", "done after 4 words", done_cnt - d0, 1);
        pulse(16'hDEAD, 0, 0, "R8");
        gap(5);
        chk(done_cnt == d0 + 1, "R8", "no second done", done_cnt - d0, 1);

        // T2: checksum enabled, count 5 -> 4 words
        d0 = done_cnt;
        send_cmd(mk(1, 4, 5), 1'b1, 1);
        wait_strobe(mk(1, 4, 5));
        gap(3);
        for (int i = 0; i < 3; i++) begin
            pulse(16'hB200 + 16'(i), 1, i, "R8");
            gap(59);
        end
        chk(done_cnt == d0, "R8", "no done after 3 of 4", done_cnt - d0, 0);
        pulse(16'hB203, 1, 3, "R8");
        gap(5);
        chk(done_cnt == d0 + 1, "R8", "done after 4 of 5", done_cnt - d0, 1);
        w0 = wr_cnt;
        gap(60);
        pulse(16'hB204, 0, 0, "R8");
        gap(5);
        chk(wr_cnt == w0, "R8", "fifth word not written", wr_cnt - w0, 0);

        // T3: wrap-around transmit keeps the buffer
        w0 = wr_cnt;
        send_cmd(mk(1, 30, 2), 1'b0, 0);
        wait_strobe(mk(1, 30, 2));
        chk(wr_cnt == w0, "R3", "no clearing writes", wr_cnt - w0, 0);
        d0 = done_cnt;
        gap(2);
        pulse(16'hC300, 1, 0, "R6");
        gap(69);
        pulse(16'hC301, 1, 1, "R6");
        gap(5);
        chk(done_cnt == d0 + 1, "R7", "wrap load done", done_cnt - d0, 1);

        // T4: busy skips the load
        busy = 1'b1;
        send_cmd(mk(1, 6, 3), 1'b0, 1);
        wait_strobe(mk(1, 6, 3));
        busy = 1'b0;
        d0 = done_cnt; e0 = err_cnt; w0 = wr_cnt;
        for (int i = 0; i < 3; i++) begin
            gap(2);
            pulse(16'hE400 + 16'(i), 0, 0, "R5");
            gap(97);
        end
        gap(600);
        chk(wr_cnt == w0, "R5", "no writes when busy", wr_cnt - w0, 0);
        chk(done_cnt == d0 && err_cnt == e0, "R5", "no done/err when busy",
            (done_cnt - d0) + (err_cnt - e0), 0);

        // T5: receive command clears but gives no strobe
        w0 = wr_cnt;
        send_cmd(mk(0, 3, 4), 1'b0, 1);
        low_seen = 0;
        for (int i = 0; i < 600; i++) begin
            if (!cmd_strb_n) low_seen = 1;
            @(negedge clk);
        end
        chk(!low_seen, "R4", "no strobe for receive", int'(low_seen), 0);
        chk(wr_cnt - w0 == 32, "R2", "clear write count", wr_cnt - w0, 32);

        // T6: lower rate limit
        d0 = done_cnt;
        send_cmd(mk(1, 2, 3), 1'b0, 1);
        wait_strobe(mk(1, 2, 3));
        gap(4);
        pulse(16'h9000, 1, 0, "R9");
        gap(48);
        pulse(16'h9BAD, 0, 0, "R9");
        pulse(16'h9001, 1, 1, "R9");
        gap(49);
        pulse(16'h9002, 1, 2, "R9");
        gap(5);
        chk(done_cnt == d0 + 1, "R9", "done with 1us spacing", done_cnt - d0, 1);

        // T7: 16 us gap accepted, longer gap times out
        d0 = done_cnt; e0 = err_cnt;
        send_cmd(mk(1, 7, 6), 1'b0, 1);
        wait_strobe(mk(1, 7, 6));
        gap(2);
        pulse(16'h7000, 1, 0, "R10");
        gap(799);
        pulse(16'h7001, 1, 1, "R10");
        gap(700);
        chk(err_cnt == e0, "R10", "no error before 16us", err_cnt - e0, 0);
        gap(200);
        chk(err_cnt == e0 + 1, "R10", "timeout error", err_cnt - e0, 1);
        chk(done_cnt == d0, "R10", "no done after timeout", done_cnt - d0, 0);
        w0 = wr_cnt;
        pulse(16'h7002, 0, 0, "R10");
        gap(5);
        chk(wr_cnt == w0, "R10", "burst ended", wr_cnt - w0, 0);

        // T8: word count 0 means 32
        d0 = done_cnt;
        send_cmd(mk(1, 9, 0), 1'b0, 1);
        wait_strobe(mk(1, 9, 0));
        gap(3);
        for (int i = 0; i < 32; i++) begin
            pulse(16'h5000 + 16'(i * 3), 1, i, "R7");
            gap(49);
        end
        chk(done_cnt == d0 + 1, "R7", "done after 32 words", done_cnt - d0, 1);

        // T9: new command abandons a burst in progress
        d0 = done_cnt; e0 = err_cnt;
        send_cmd(mk(1, 8, 8), 1'b0, 1);
        wait_strobe(mk(1, 8, 8));
        gap(2);
        pulse(16'h6000, 1, 0, "R11");
        gap(59);
        pulse(16'h6001, 1, 1, "R11");
        gap(10);
        send_cmd(mk(0, 5, 2), 1'b0, 1);
        gap(1000);
        chk(done_cnt == d0 && err_cnt == e0, "R11", "abandoned burst silent",
            (done_cnt - d0) + (err_cnt - e0), 0);
        chk(cmd_strb_n == 1'b1, "R11", "no strobe after restart", int'(cmd_strb_n), 1);

        // T10: checksum with count 1 completes at strobe end
        d0 = done_cnt; w0 = wr_cnt;
        send_cmd(mk(1, 1, 1), 1'b1, 1);
        wait_strobe(mk(1, 1, 1));
        gap(2);
        chk(done_cnt == d0 + 1, "R8", "done with no words", done_cnt - d0, 1);
        chk(wr_cnt - w0 == 32, "R8", "only clear writes", wr_cnt - w0, 32);

        gap(5);
        chk(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog expired: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule